// File: doc/BRIEF.md
# Burst Return Pipe with Direction-Dependent Residency

This block sits between a memory command scheduler and the logic that consumes returned data bursts. Each issued read or write command pushes one entry, which stands for one data burst of a larger request. An entry may only leave the pipe after it has stayed inside for a minimum number of cycles. That minimum is the read latency while the bus is in read direction, and the write latency while it is in write direction. The direction follows the most recently accepted command, so the required stay changes as soon as the traffic type changes.

The pipe holds one entry more than the read latency. Its full indication tells the scheduler to stop issuing data commands. For every request tag, the block counts how many bytes have been delivered. Each release adds one burst's worth of bytes, and when the running count reaches the request size the block reports completion. The completion report carries the tag and the latency measured from the request's insertion time. A look-ahead output tells the consumer whether releasing the current head would finish its request.

A free-running cycle counter gives callers the time base for insertion stamps. Data payload and the memory device interface are handled elsewhere.

Top module: `burst_return_pipe`

## Requirements
- R1: While reset is asserted, the pipe is empty. Its outputs then show read direction (`wr_mode_o`=0), `full_o`=0, `head_ready_o`=0, `peek_done_o`=0, `done_o`=0 and `now_o`=0. After reset, `now_o` increments by one every cycle.
- R2: The capacity is RD_LAT+1 entries, and `full_o` is high exactly when that many are held. A push while `full_o` is high is dropped, even if a pop happens in the same cycle. In the cycle after such a push, `ovf_o` is 1.
- R3: In read direction, an entry pushed in the cycle where `now_o`=T makes `head_ready_o` high (if it is at the head) from the cycle where `now_o`=T+RD_LAT, and not before.
- R4: An accepted push with `push_wr_i`=1 sets write direction (`wr_mode_o`=1) from the next cycle. An accepted push with `push_wr_i`=0 sets read direction. No other event changes the direction.
- R5: The required stay is taken from the direction in force at the time of release, so entries already waiting are also judged against WR_LAT once write direction is set.
- R6: Entries leave in the order they were accepted, and `head_tag_o` shows the tag of the oldest entry.
- R7: Every accepted pop adds BURST_BYTES (BL×BUS_BYTES×DEVS) to the delivered count of the head's tag. If the new count is at least the head's size field, `done_o` pulses in the next cycle with `done_tag_o` equal to that tag, and the tag's count returns to 0. Otherwise the count is kept and `done_o` stays 0.
- R8: `peek_done_o` is 1 exactly when the pipe is non-empty and the head tag's delivered count plus BURST_BYTES is at least the head's size.
- R9: `done_lat_o` equals `now_o` in the pop cycle minus the `push_birth_i` stored with the completing burst, modulo 2^TS_W.
- R10: `pop_i` has no effect while `head_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Enqueue one burst entry |
| push_wr_i | input | 1 | 1 = burst belongs to a write command, 0 = read |
| push_tag_i | input | TAG_W | Request tag of the burst |
| push_size_i | input | SZ_W | Total request size in bytes |
| push_birth_i | input | TS_W | Request insertion time on the `now_o` time base |
| full_o | output | 1 | Pipe holds RD_LAT+1 entries |
| ovf_o | output | 1 | Previous-cycle push was dropped because the pipe was full |
| now_o | output | TS_W | Free-running cycle counter |
| wr_mode_o | output | 1 | Current bus direction, 1 = write |
| head_ready_o | output | 1 | Head entry has served its required stay |
| head_tag_o | output | TAG_W | Tag of the head entry (valid when non-empty) |
| peek_done_o | output | 1 | Releasing the head would complete its request |
| pop_i | input | 1 | Release the head burst |
| done_o | output | 1 | A request completed on the previous pop |
| done_tag_o | output | TAG_W | Tag of the completed request |
| done_lat_o | output | TS_W | Insertion-to-completion latency of that request |

## Verification
The in-design properties assume that the consumer may raise `pop_i` at any time, but that the storage only sees pushes and pops the top has already qualified. Capacity and underflow checks therefore depend on the top's gating, not on the stimulus. Byte accounting assumes that bursts of one tag are not shared by two requests in flight at once. The bench reference model applies the same per-tag rule, so random tags and sizes stay consistent between the two. Birth stamps are drawn at most a few dozen cycles behind `now_o`, and runs are short enough that latencies never wrap.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // required stay for the direction in force
    function automatic int unsigned stay_for(input dir_e dir,
                                             input int unsigned rd_lat,
                                             input int unsigned wr_lat);
        return (dir == DIR_WR) ? wr_lat : rd_lat;
    endfunction

endpackage

// File: rtl/rp_fifo.sv
module rp_fifo #(
    parameter int  DEPTH   = 6,
    parameter type entry_t = logic [7:0]
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_i,
    input  entry_t wdata_i,
    input  logic   pop_i,
    output entry_t head_o,
    output logic   empty_o,
    output logic   full_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t   c_d, c_q;
    entry_t mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        c_d = c_q;
        if (push_i) c_d.wr = bump(c_q.wr);
        if (pop_i)  c_d.rd = bump(c_q.rd);
        c_d.cnt = c_q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[c_q.wr] <= wdata_i;
    end

    assign head_o  = mem_q[c_q.rd];
    assign empty_o = (c_q.cnt == '0);
    assign full_o  = (c_q.cnt == CW'(DEPTH));

    // R2: the top never lets a push reach a full store
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R10: a release only happens with something stored
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    // R2: occupancy bounded by capacity
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/rp_acct.sv
module rp_acct #(
    parameter int TAG_W = 2,
    parameter int SZ_W  = 8,
    parameter int BURST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic             upd_i,
    output logic             fin_o
);

    localparam int NTAG = 1 << TAG_W;

    logic [SZ_W-1:0] got_d [NTAG];
    logic [SZ_W-1:0] got_q [NTAG];

    // one more burst reaches the size: compare one bit wider
    assign fin_o = ({1'b0, got_q[tag_i]} + (SZ_W+1)'(BURST)) >= {1'b0, size_i};

    for (genvar g = 0; g < NTAG; g++) begin : g_tag
        always_comb begin
            got_d[g] = got_q[g];
            if (upd_i && tag_i == TAG_W'(g)) begin
                got_d[g] = fin_o ? '0 : got_q[g] + SZ_W'(BURST);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) got_q[g] <= '0;
            else        got_q[g] <= got_d[g];
        end

        // R7: a completing release leaves the tag's count at zero
        p_clear_on_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_i && tag_i == TAG_W'(g) && fin_o) |=> (got_q[g] == '0));

        // R7: other tags are untouched by a release
        p_other_tag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_i && tag_i != TAG_W'(g)) |=> $stable(got_q[g]));
    end

endmodule

// File: rtl/burst_return_pipe.sv
module burst_return_pipe
    import rp_pkg::*;
#(
    parameter int RD_LAT    = 5,
    parameter int WR_LAT    = 3,
    parameter int BL        = 4,
    parameter int BUS_BYTES = 2,
    parameter int DEVS      = 2,
    parameter int TAG_W     = 2,
    parameter int SZ_W      = 8,
    parameter int TS_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             push_wr_i,
    input  logic [TAG_W-1:0] push_tag_i,
    input  logic [SZ_W-1:0]  push_size_i,
    input  logic [TS_W-1:0]  push_birth_i,
    output logic             full_o,
    output logic             ovf_o,
    output logic [TS_W-1:0]  now_o,
    output logic             wr_mode_o,
    output logic             head_ready_o,
    output logic [TAG_W-1:0] head_tag_o,
    output logic             peek_done_o,
    input  logic             pop_i,
    output logic             done_o,
    output logic [TAG_W-1:0] done_tag_o,
    output logic [TS_W-1:0]  done_lat_o
);

    localparam int DEPTH       = RD_LAT + 1;
    localparam int BURST_BYTES = BL * BUS_BYTES * DEVS;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SZ_W-1:0]  size;
        logic [TS_W-1:0]  birth;
        logic [TS_W-1:0]  stamp;
    } ent_t;

    typedef struct packed {
        logic [TS_W-1:0]  now;
        dir_e             dir;
        logic             ovf;
        logic             done;
        logic [TAG_W-1:0] dtag;
        logic [TS_W-1:0]  dlat;
    } st_t;

    st_t             s_d, s_q;
    ent_t            wentry, head;
    logic            empty, full, push_ok, pop_ok, ready, fin;
    logic [TS_W-1:0] age, need;

    assign wentry = '{tag: push_tag_i, size: push_size_i,
                      birth: push_birth_i, stamp: s_q.now};

    assign push_ok = push_i && !full;
    assign age     = s_q.now - head.stamp;
    assign need    = TS_W'(stay_for(s_q.dir, RD_LAT, WR_LAT));
    assign ready   = !empty && (age >= need);
    assign pop_ok  = pop_i && ready;

    rp_fifo #(
        .DEPTH   (DEPTH),
        .entry_t (ent_t)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_ok),
        .wdata_i (wentry),
        .pop_i   (pop_ok),
        .head_o  (head),
        .empty_o (empty),
        .full_o  (full)
    );

    rp_acct #(
        .TAG_W (TAG_W),
        .SZ_W  (SZ_W),
        .BURST (BURST_BYTES)
    ) u_acct (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_i  (head.tag),
        .size_i (head.size),
        .upd_i  (pop_ok),
        .fin_o  (fin)
    );

    always_comb begin
        s_d      = s_q;
        s_d.now  = s_q.now + TS_W'(1);
        s_d.ovf  = push_i && full;
        s_d.done = 1'b0;
        if (push_ok) s_d.dir = push_wr_i ? DIR_WR : DIR_RD;
        if (pop_ok && fin) begin
            s_d.done = 1'b1;
            s_d.dtag = head.tag;
            s_d.dlat = s_q.now - head.birth;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full_o       = full;
    assign ovf_o        = s_q.ovf;
    assign now_o        = s_q.now;
    assign wr_mode_o    = (s_q.dir == DIR_WR);
    assign head_ready_o = ready;
    assign head_tag_o   = head.tag;
    assign peek_done_o  = !empty && fin;
    assign done_o       = s_q.done;
    assign done_tag_o   = s_q.dtag;
    assign done_lat_o   = s_q.dlat;

    // R2: a refused push is flagged one cycle later
    p_ovf_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> ovf_o);

    // R4: an accepted write push turns the bus to write
    p_turn_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && push_wr_i) |=> wr_mode_o);

    // R4: an accepted read push turns the bus to read
    p_turn_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !push_wr_i) |=> !wr_mode_o);

    // R4: without an accepted push the direction holds
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && !full_o) |=> $stable(wr_mode_o));

    // R7: completion only follows a qualified release
    p_done_after_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(pop_i && head_ready_o));

    // R1: the time base advances by one every cycle
    p_time_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (now_o == $past(now_o) + TS_W'(1)));

endmodule

// File: tb/sim_burst_return_pipe.sv
module sim_burst_return_pipe;

    localparam int RD_LAT = 5;
    localparam int WR_LAT = 3;
    localparam int DEPTH  = RD_LAT + 1;
    localparam int BURST  = 16;
    localparam int TAG_W  = 2;
    localparam int SZ_W   = 8;
    localparam int TS_W   = 12;
    localparam int NTAG   = 4;
    localparam int MASK   = (1 << TS_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             push_i = 0, push_wr_i = 0, pop_i = 0;
    logic [TAG_W-1:0] push_tag_i = '0;
    logic [SZ_W-1:0]  push_size_i = '0;
    logic [TS_W-1:0]  push_birth_i = '0;
    logic             full_o, ovf_o, wr_mode_o, head_ready_o, peek_done_o, done_o;
    logic [TS_W-1:0]  now_o, done_lat_o;
    logic [TAG_W-1:0] head_tag_o, done_tag_o;

    burst_return_pipe #(
        .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .BL(4), .BUS_BYTES(2), .DEVS(2),
        .TAG_W(TAG_W), .SZ_W(SZ_W), .TS_W(TS_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_wr_i(push_wr_i),
        .push_tag_i(push_tag_i), .push_size_i(push_size_i),
        .push_birth_i(push_birth_i), .full_o(full_o), .ovf_o(ovf_o),
        .now_o(now_o), .wr_mode_o(wr_mode_o), .head_ready_o(head_ready_o),
        .head_tag_o(head_tag_o), .peek_done_o(peek_done_o), .pop_i(pop_i),
        .done_o(done_o), .done_tag_o(done_tag_o), .done_lat_o(done_lat_o)
    );

    // behavioural reference
    typedef struct {
        int tag;
        int size;
        int birth;
        int stamp;
    } m_ent_t;

    m_ent_t mq[$];
    int m_cyc = 0, m_dir = 0, m_ovf = 0, m_done = 0, m_dtag = 0, m_dlat = 0;
    int m_del[NTAG];
    int n_chk = 0, n_bad = 0;
    bit cmp_en = 0, ended = 0;

    initial for (int i = 0; i < NTAG; i++) m_del[i] = 0;

    function automatic int m_ready();
        if (mq.size() == 0) return 0;
        return (((m_cyc - mq[0].stamp) & MASK) >= (m_dir ? WR_LAT : RD_LAT)) ? 1 : 0;
    endfunction

    function automatic int m_peek();
        if (mq.size() == 0) return 0;
        return (m_del[mq[0].tag] + BURST >= mq[0].size) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            automatic int full_now = (mq.size() >= DEPTH) ? 1 : 0;
            automatic int pop_ok = (pop_i && m_ready()) ? 1 : 0;
            m_ovf  = (push_i && full_now) ? 1 : 0;
            m_done = 0;
            if (pop_ok) begin
                automatic m_ent_t e = mq.pop_front();
                automatic int nd = m_del[e.tag] + BURST;
                if (nd >= e.size) begin
                    m_done = 1;
                    m_dtag = e.tag;
                    m_dlat = (m_cyc - e.birth) & MASK;
                    m_del[e.tag] = 0;
                end else begin
                    m_del[e.tag] = nd;
                end
            end
            if (push_i && !full_now) begin
                automatic m_ent_t n;
                n.tag = int'(push_tag_i);
                n.size = int'(push_size_i);
                n.birth = int'(push_birth_i);
                n.stamp = m_cyc;
                mq.push_back(n);
                m_dir = push_wr_i ? 1 : 0;
            end
            m_cyc = (m_cyc + 1) & MASK;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !ended) begin
            chk("R1", "now", int'(now_o), m_cyc);
            chk("R2", "full", int'(full_o), (mq.size() >= DEPTH) ? 1 : 0);
            chk("R2", "ovf", int'(ovf_o), m_ovf);
            chk("R4", "wr_mode", int'(wr_mode_o), m_dir);
            chk("R3", "head_ready", int'(head_ready_o), m_ready());
            chk("R8", "peek_done", int'(peek_done_o), m_peek());
            if (mq.size() > 0) chk("R6", "head_tag", int'(head_tag_o), mq[0].tag);
            chk("R7", "done", int'(done_o), m_done);
            if (m_done) begin
                chk("R7", "done_tag", int'(done_tag_o), m_dtag);
                chk("R9", "done_lat", int'(done_lat_o), m_dlat);
            end
        end
    end

    task automatic step(input bit ps, input bit wr, input int tag, input int size,
                        input int back, input bit pp);
        @(negedge clk);
        #1;
        push_i       = ps;
        push_wr_i    = wr;
        push_tag_i   = TAG_W'(tag);
        push_size_i  = SZ_W'(size);
        push_birth_i = TS_W'((m_cyc - back) & MASK);
        pop_i        = pp;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 60 && mq.size() > 0; i++) step(0, 0, 0, 0, 0, 1);
        idle();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset full", int'(full_o), 0);
        chk("R1", "reset wr_mode", int'(wr_mode_o), 0);
        chk("R1", "reset head_ready", int'(head_ready_o), 0);
        chk("R1", "reset peek", int'(peek_done_o), 0);
        chk("R1", "reset done", int'(done_o), 0);
        chk("R1", "reset now", int'(now_o), 0);
        #1 rst_n = 1'b1;
        cmp_en = 1;

        // R3: read stay measured by hand; R9 latency by hand
        step(1, 0, 0, 16, 4, 0);
        for (int k = 1; k <= RD_LAT; k++) begin
            idle();
            chk("R3", "ready after k cycles", int'(head_ready_o), (k >= RD_LAT) ? 1 : 0);
        end
        step(0, 0, 0, 0, 0, 1);
        idle();
        chk("R7", "single burst completes", int'(done_o), 1);
        chk("R9", "hand latency", int'(done_lat_o), RD_LAT + 5);

        // R10: early pop ignored; R8 peek both ways; R7 two-burst request
        step(1, 0, 1, 32, 2, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R8", "peek first of two bursts", int'(peek_done_o), 0);
        for (int k = 0; k < RD_LAT; k++) idle();
        chk("R10", "entry survives early pop", int'(head_ready_o), 1);
        chk("R10", "tag survives early pop", int'(head_tag_o), 1);
        step(0, 0, 0, 0, 0, 1);
        idle();
        chk("R7", "no done after partial", int'(done_o), 0);
        step(1, 0, 1, 32, 9, 0);
        idle();
        chk("R8", "peek last burst", int'(peek_done_o), 1);
        drain();

        // R5 and R4: write push shortens the stay of a waiting read
        step(1, 0, 2, 16, 0, 0);
        step(1, 1, 3, 16, 0, 0);
        idle();
        chk("R4", "write direction set", int'(wr_mode_o), 1);
        chk("R5", "not ready at age 2", int'(head_ready_o), 0);
        idle();
        chk("R5", "ready at write stay", int'(head_ready_o), 1);
        drain();
        step(1, 0, 0, 16, 0, 0);
        idle();
        chk("R4", "read direction back", int'(wr_mode_o), 0);
        drain();

        // R2: fill beyond capacity
        for (int i = 0; i < DEPTH; i++) step(1, 0, i % NTAG, 16, 1, 0);
        step(1, 0, 3, 16, 1, 0);
        idle();
        chk("R2", "full at capacity", int'(full_o), 1);
        chk("R2", "overflow flagged", int'(ovf_o), 1);
        drain();

        // mixed random traffic, compared every cycle
        for (int c = 0; c < 3000; c++) begin
            automatic int sz = ($urandom_range(0, 3) == 0) ? 8 : 16 * $urandom_range(1, 3);
            step($urandom_range(0, 1), $urandom_range(0, 9) < 3, $urandom_range(0, NTAG - 1),
                 sz, $urandom_range(0, 30), $urandom_range(0, 9) < 6);
        end
        drain();
        finish_run();
    end

endmodule